// File: doc/BRIEF.md
# Stepped Regulator Divisor Loader

This block turns a requested CPU clock frequency, given in kHz, into a 12-bit regulator divisor and writes it to the regulator over a three-wire serial link: data, shift clock and a load line. The load line is held low while a word is shifted and pulses high to latch it. A large change in divisor could make the supply dip, so the block does not jump straight to the new value. It moves the divisor toward the target in increments of at most 0x100 and sends one complete serial word for each increment. It stops once the word it has just latched equals the target.

A controller pulses `start` with the frequency on `freq_khz`. It may also raise `force_load`, which makes the first word carry the target directly. This is meant for setting a known state when the supply is already close to the right level. `busy` covers the whole walk, and `done` pulses once at the end. `cur_div` always holds the last divisor that was latched. Every serial phase lasts a fixed number of system clocks, which is worked out from the clock frequency and the phase length given as parameters.

Top module: `vdiv_loader`

## Requirements
- R1: The target divisor is 0xFFF when the frequency is below 200000 kHz, 0xDE5 from 200000 up to 299999 kHz, and 0x325 from 300000 kHz upward.
- R2: On an unforced word, the value sent follows three rules. If the last latched divisor is more than 0x100 below the target, the word is that divisor plus 0x100. If it is more than 0x100 above the target, the word is that divisor minus 0x100. In every other case the word is the target itself.
- R3: When `force_load` is high with `start`, the first word of the walk is the target. Force affects only that word.
- R4: Words continue until the latched value equals the target, so a request whose target equals the current divisor still sends exactly one word. `done` is then high for exactly one cycle, and `cur_div` equals the target.
- R5: Each word is 12 bits long and is sent most significant bit first. The regulator samples `psu_data` on the rising edge of `psu_clk`, and `psu_data` does not change while `psu_clk` is high.
- R6: After the 12th clock pulse, `psu_load` rises while `psu_clk` is low and then returns low. This is the only time `psu_load` is high.
- R7: Each serial phase, including the high time of `psu_load`, lasts TICKS = CLK_FREQ_KHZ*PHASE_NS/1e6 system clocks (4 at the defaults).
- R8: During and after reset, `cur_div` is 0, `busy` and `done` are low, and all three serial outputs are low.
- R9: A `start` that arrives while `busy` is high is ignored. The walk in progress sends only its own words and still ends at its own target.
- R10: `busy` rises in the cycle after an accepted `start` and falls in the same cycle in which `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle |
| freq_khz | input | FREQ_W | Requested CPU frequency in kHz |
| force_load | input | 1 | First word carries the target directly |
| psu_data | output | 1 | Serial data to the regulator |
| psu_clk | output | 1 | Serial shift clock |
| psu_load | output | 1 | Low during a word, pulses high to latch it |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the target is latched |
| cur_div | output | 12 | Last divisor latched into the regulator |

## Verification
The hardest situation to reach is a second `start` that arrives part-way through a multi-word walk. To pass R9, that request must leave no trace in the words that follow it. The stimulus first sets the divisor to 0xDE5 and then requests 0x325, which takes eleven words. About twenty cycles in, it pulses `start` again with a different frequency and with force set. The scoreboard holds only the words of the original walk, so any extra or changed word shows up as a mismatch. Boundary frequencies are exercised on both sides of each threshold, including a request that starts from a zero divisor.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

    localparam int DIV_W = 12;
    typedef logic [DIV_W-1:0] div_t;

    localparam div_t STEP_SIZE = 12'h100;
    localparam div_t DIV_SLOW  = 12'hFFF;
    localparam div_t DIV_MID   = 12'hDE5;
    localparam div_t DIV_FAST  = 12'h325;
    localparam int   KHZ_MID   = 200000;
    localparam int   KHZ_FAST  = 300000;

    typedef enum logic [1:0] {SQ_IDLE, SQ_CALC, SQ_SEND} seq_st_e;
    typedef enum logic [2:0] {FR_IDLE, FR_DATA, FR_CLKH, FR_CLKL, FR_LDH, FR_LDL} frm_st_e;

    typedef struct packed {
        logic data;
        logic sclk;
        logic load;
    } serial_pins_t;

    function automatic div_t pick_divisor(input logic [31:0] khz);
        if (khz < 32'(KHZ_MID))       return DIV_SLOW;
        else if (khz < 32'(KHZ_FAST)) return DIV_MID;
        else                          return DIV_FAST;
    endfunction

    function automatic div_t walk_step(input div_t cur, input div_t tgt);
        int c;
        int t;
        int s;
        c = int'(cur);
        t = int'(tgt);
        s = int'(STEP_SIZE);
        if (c < t - s)      return cur + STEP_SIZE;
        else if (c > t + s) return cur - STEP_SIZE;
        else                return tgt;
    endfunction

endpackage

// File: rtl/vdiv_tick.sv
module vdiv_tick #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/vdiv_frame.sv
module vdiv_frame
    import vdiv_pkg::*;
#(
    parameter int TICKS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  div_t         value,
    input  logic         tick,
    output logic         active,
    output logic         frame_done,
    output serial_pins_t pins
);
    localparam int BIT_W = $clog2(DIV_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DIV_W - 1);

    frm_st_e          st;
    div_t             shreg;
    logic [BIT_W-1:0] bit_idx;

    assign active = (st != FR_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FR_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            pins       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (st == FR_IDLE) begin
                if (launch) begin
                    shreg     <= value;
                    bit_idx   <= '0;
                    pins.sclk <= 1'b0;
                    pins.load <= 1'b0;
                    st        <= FR_DATA;
                end
            end else if (tick) begin
                unique case (st)
                    FR_DATA: begin
                        pins.data <= shreg[DIV_W-1];
                        shreg     <= {shreg[DIV_W-2:0], 1'b0};
                        st        <= FR_CLKH;
                    end
                    FR_CLKH: begin
                        pins.sclk <= 1'b1;
                        st        <= FR_CLKL;
                    end
                    FR_CLKL: begin
                        pins.sclk <= 1'b0;
                        if (bit_idx == LAST_BIT) begin
                            st <= FR_LDH;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            st      <= FR_DATA;
                        end
                    end
                    FR_LDH: begin
                        pins.load <= 1'b1;
                        st        <= FR_LDL;
                    end
                    FR_LDL: begin
                        pins.load  <= 1'b0;
                        pins.data  <= 1'b0;
                        frame_done <= 1'b1;
                        st         <= FR_IDLE;
                    end
                    default: st <= FR_IDLE;
                endcase
            end
        end
    end

    // Length of the current load pulse, used only by the checks below.
    logic [15:0] ld_len;
    always_ff @(posedge clk) begin
        if (rst || !pins.load) ld_len <= '0;
        else                   ld_len <= ld_len + 1'b1;
    end

    // R5
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        pins.sclk |-> $stable(pins.data));

    // R6
    load_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        pins.load |-> !pins.sclk);

    // R7
    load_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.load) |-> ($past(ld_len) == 16'(TICKS - 1)));
endmodule

// File: rtl/vdiv_seq.sv
module vdiv_seq
    import vdiv_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic              force_in,
    input  logic              frame_done,
    output logic              launch,
    output div_t              launch_val,
    output div_t              cur_div,
    output logic              busy,
    output logic              done
);
    seq_st_e st;
    div_t    tgt;
    logic    frc;
    logic    launch_forced;

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= SQ_IDLE;
            tgt           <= '0;
            frc           <= 1'b0;
            cur_div       <= '0;
            busy          <= 1'b0;
            done          <= 1'b0;
            launch        <= 1'b0;
            launch_val    <= '0;
            launch_forced <= 1'b0;
        end else begin
            done   <= 1'b0;
            launch <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        tgt  <= pick_divisor(32'(freq_khz));
                        frc  <= force_in;
                        busy <= 1'b1;
                        st   <= SQ_CALC;
                    end
                end
                SQ_CALC: begin
                    launch        <= 1'b1;
                    launch_val    <= frc ? tgt : walk_step(cur_div, tgt);
                    launch_forced <= frc;
                    frc           <= 1'b0;
                    st            <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (frame_done) begin
                        cur_div <= launch_val;
                        if (launch_val == tgt) begin
                            done <= 1'b1;
                            busy <= 1'b0;
                            st   <= SQ_IDLE;
                        end else begin
                            st <= SQ_CALC;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && !launch_forced) |->
            ((int'(launch_val) - int'(cur_div) <= int'(STEP_SIZE)) &&
             (int'(cur_div) - int'(launch_val) <= int'(STEP_SIZE))));

    // R3
    force_target_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && launch_forced) |-> (launch_val == tgt));

    // R4
    done_at_target_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cur_div == tgt));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(tgt));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

// File: rtl/vdiv_loader.sv
module vdiv_loader
    import vdiv_pkg::*;
#(
    parameter int CLK_FREQ_KHZ = 4000,
    parameter int PHASE_NS     = 1000,
    parameter int FREQ_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic              force_load,
    output logic              psu_data,
    output logic              psu_clk,
    output logic              psu_load,
    output logic              busy,
    output logic              done,
    output logic [11:0]       cur_div
);
    localparam longint RAW_TICKS = (longint'(CLK_FREQ_KHZ) * PHASE_NS) / 1000000;
    localparam int     TICKS     = (RAW_TICKS < 1) ? 1 : int'(RAW_TICKS);

    logic         launch;
    div_t         launch_val;
    logic         frame_done;
    logic         fr_active;
    logic         tick;
    serial_pins_t pins;

    vdiv_seq #(.FREQ_W(FREQ_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .freq_khz   (freq_khz),
        .force_in   (force_load),
        .frame_done (frame_done),
        .launch     (launch),
        .launch_val (launch_val),
        .cur_div    (cur_div),
        .busy       (busy),
        .done       (done)
    );

    vdiv_tick #(.TICKS(TICKS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (fr_active),
        .tick (tick)
    );

    vdiv_frame #(.TICKS(TICKS)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .value      (launch_val),
        .tick       (tick),
        .active     (fr_active),
        .frame_done (frame_done),
        .pins       (pins)
    );

    assign psu_data = pins.data;
    assign psu_clk  = pins.sclk;
    assign psu_load = pins.load;

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (cur_div == '0 && !busy && !psu_load && !psu_clk));
endmodule

// File: tb/test_vdiv_loader.sv
module test_vdiv_loader;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] freq_khz = '0;
    logic        force_load = 1'b0;
    logic        psu_data, psu_clk, psu_load, busy, done;
    logic [11:0] cur_div;

    vdiv_loader #(.CLK_FREQ_KHZ(4000), .PHASE_NS(1000), .FREQ_W(32)) i_vdiv_loader (
        .clk(clk), .rst(rst), .start(start), .freq_khz(freq_khz),
        .force_load(force_load), .psu_data(psu_data), .psu_clk(psu_clk),
        .psu_load(psu_load), .busy(busy), .done(done), .cur_div(cur_div)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [11:0] exp_q[$];
    logic [11:0] model_cur = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ref_pick(input int khz);
        if (khz < 200000)      return 12'hFFF;
        else if (khz < 300000) return 12'hDE5;
        else                   return 12'h325;
    endfunction

    function automatic logic [11:0] ref_step(input logic [11:0] c, input logic [11:0] t);
        if (int'(c) < int'(t) - 256)      return 12'(int'(c) + 256);
        else if (int'(c) > int'(t) + 256) return 12'(int'(c) - 256);
        else                              return t;
    endfunction

    // Monitor: decodes serial words and compares against the scoreboard.
    logic        p_clk = 1'b0, p_ld = 1'b0;
    logic [11:0] rx = '0;
    int          nbits = 0;
    int          ld_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (psu_clk && !p_clk) begin
                rx = {rx[10:0], psu_data};
                nbits++;
            end
            if (psu_load && !p_ld) begin
                chk(nbits == 12, "R5 bit count", nbits, 12);
                chk(!psu_clk, "R6 load with clock low", int'(psu_clk), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", int'(rx), 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(rx == e, "R2/R5 word value", int'(rx), int'(e));
                end
                nbits  = 0;
                ld_len = 0;
            end
            if (psu_load) ld_len++;
            if (!psu_load && p_ld)
                chk(ld_len == TICKS, "R7 load pulse width", ld_len, TICKS);
        end
        p_clk = psu_clk;
        p_ld  = psu_load;
    end

    task automatic request(input int khz, input bit frc, input string tag, input bit poke);
        logic [11:0] tgt, c, s;
        bit first;
        bit seen;
        int words;
        tgt = ref_pick(khz);
        c = model_cur;
        first = 1'b1;
        words = 0;
        do begin
            s = (frc && first) ? tgt : ref_step(c, tgt);
            exp_q.push_back(s);
            words++;
            c = s;
            first = 1'b0;
        end while (c != tgt);
        @(negedge clk);
        freq_khz = 32'(khz); force_load = frc; start = 1'b1;
        @(negedge clk);
        start = 1'b0; force_load = 1'b0;
        // R10: busy rises the cycle after start
        chk(busy == 1'b1, {tag, " R10 busy after start"}, int'(busy), 1);
        seen = 1'b0;
        for (int i = 0; i < 8000 && !seen; i++) begin
            if (poke && i == 20) begin
                freq_khz = 32'd150000; force_load = 1'b1; start = 1'b1;
            end else if (poke && i == 21) begin
                start = 1'b0; force_load = 1'b0;
            end
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        start = 1'b0;
        chk(seen, {tag, " R4 done seen"}, int'(seen), 1);
        chk(cur_div == tgt, {tag, " R1/R4 final divisor"}, int'(cur_div), int'(tgt));
        chk(!busy, {tag, " R10 busy low with done"}, int'(busy), 0);
        chk(exp_q.size() == 0, {tag, " R4 word count"}, exp_q.size(), 0);
        @(negedge clk);
        chk(!done, {tag, " R4 done one cycle"}, int'(done), 0);
        model_cur = tgt;
        if (words < 0) $display("unreachable");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(cur_div == 12'h000, "R8 cur_div in reset", int'(cur_div), 0);
        chk({psu_data, psu_clk, psu_load} == 3'b000, "R8 pins in reset",
            int'({psu_data, psu_clk, psu_load}), 0);
        chk(!busy && !done, "R8 busy/done in reset", int'({busy, done}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(cur_div == 12'h000 && !busy, "R8 after reset", int'(cur_div), 0);

        request(350000, 1'b0, "R1 R2 up-walk from zero", 1'b0);
        request(100000, 1'b1, "R3 forced slow", 1'b0);
        request(250000, 1'b0, "R2 down-walk", 1'b0);
        request(299999, 1'b0, "R1 R4 same target", 1'b0);
        request(300000, 1'b0, "R9 ignored start", 1'b1);
        request(199999, 1'b1, "R1 R3 forced boundary", 1'b0);
        request(200000, 1'b0, "R1 mid boundary", 1'b0);
        request(250000, 1'b1, "R3 forced at target", 1'b0);

        repeat (10) @(negedge clk);
        chk(!busy && !psu_load, "R9 quiet after run", int'({busy, psu_load}), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule